// File: doc/BRIEF.md
# I/O Expander Command Decoder

This block interprets a stream of command bytes from a serial receiver and runs the register file of a ten-line I/O expander. The registers are split into 5-bit halves: a low half covers lines 0 to 4 and a high half covers lines 5 to 9. The register file holds the pin sample (raw) and a per-line polarity complement, from which the input value is derived. It also holds the direction and output registers, and four interrupt-qualifier masks (low-level, high-level, rising, falling). Beside these sit an interrupt enable bit and an interrupt pending bit, an 8-bit oscillator trim register, a pointer into a fixed identification string, and a glitch counter that saturates.

Each byte arrives as a one-cycle `rx_valid` strobe. Most opcodes act in the clock edge that accepts them. Some carry their data inside the opcode itself. A group of set-register opcodes takes the next byte as a 5-bit operand. Query opcodes return one byte to the transmitter as a one-cycle `tx_req` pulse with `tx_byte`.

Top module: `ioexp_cmd_decoder`

## Requirements
- R1: After reset, `out_bits` is 0 and `dir_bits` is all ones (0x3FF). Both interrupt bits are 0, `trim` equals TRIM_INIT (0x80), the ID pointer and glitch count are 0, and `tx_req` is low.
- R2: Opcode 0000_iiih returns a register half, with h=0 for the low half and h=1 for the high half. The register is selected by iii: 0 input (raw XOR complement), 1 complement, 2 direction, 3 raw pin sample, 4 low-level mask, 5 high-level mask, 6 rising mask, 7 falling mask. The reply holds the half in bits 4..0 with bits 7..5 zero.
- R3: Opcode 0x10 returns the output low half and 0x11 returns the output high half.
- R4: Opcodes 0x12/0x13 (complement low/high), 0x14/0x15 (direction low/high) and 0x18..0x1F (low-level, high-level, rising, falling masks, each low then high) take the next accepted byte as an operand. Its bits 4..0 are written to the selected half. That byte is never decoded as an opcode and never produces a reply.
- R5: Opcode 0x16 clears both output halves. Opcode 0x17 returns every register to its R1 state except `trim`.
- R6: Opcode 001d_dddd loads the output low half with d, and 010d_dddd loads the output high half with d.
- R7: Opcode 011v_bbbb writes v to output line b when b is 0..9. When b is 10..15, the outputs do not change.
- R8: Opcodes 10xx_xxxx, 110x_xxxx, 1110_0xxx and 1110_1xxx other than 0xEF change no state and give no reply.
- R9: Opcode 0xEF returns {6'b0, enable, pending}. Opcode 1111_00ep writes both bits, 1111_010p writes pending only, and 1111_011e writes enable only.
- R10: Opcode 0xF8 subtracts 4 from `trim` and 0xF9 adds 4, both modulo 256. Opcode 0xFA returns `trim` and 0xFB returns 0x00.
- R11: Opcode 0xFC returns ID byte k = ID_SEED + ID_STEP*k (mod 256) for the current pointer k, then advances the pointer, wrapping from ID_LEN-1 to 0. Opcode 0xFD sets the pointer to 0. The defaults are seed 0x49, step 0x11 and length 6.
- R12: Opcode 0xFF increments the glitch count, which holds at 0xFF. Opcode 0xFE returns the count and clears it.
- R13: A reply raises `tx_req` for exactly one cycle, in the cycle after the clock edge that accepts the opcode. Register updates are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Received command or operand byte |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_byte` |
| pin_in | input | 10 | Line levels, sampled every cycle into the raw register |
| tx_byte | output | 8 | Reply byte, valid while `tx_req` is high |
| tx_req | output | 1 | One-cycle request to send `tx_byte` |
| out_bits | output | 10 | Output register, line 0 in bit 0 |
| dir_bits | output | 10 | Direction register, line 0 in bit 0 |
| irq_pending | output | 1 | Interrupt pending bit |
| irq_enable | output | 1 | Interrupt enable bit |
| trim | output | 8 | Oscillator trim value |

## Verification
Every result is registered once. A reply and any register change therefore appear one clock after the edge that samples `rx_valid`. The driver raises the strobe at a falling edge and inspects the ports at the next falling edge, half a period after that accepting edge. It then holds the line idle for one more cycle and confirms that `tx_req` has dropped again. The monitor compares the reply bytes against a queue that the driver fills before each strobe. Any reply that arrives with no expectation queued, or any expectation left unmatched at the end, counts as a failure.

// File: rtl/ioexp_cmd_decoder.sv
module ioexp_cmd_decoder #(
  parameter int HW = 5,
  parameter int ID_LEN = 6,
  parameter logic [7:0] ID_SEED = 8'h49,
  parameter logic [7:0] ID_STEP = 8'h11,
  parameter logic [7:0] TRIM_INIT = 8'h80,
  parameter logic [7:0] TRIM_STEP = 8'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      rx_byte,
  input  logic            rx_valid,
  input  logic [2*HW-1:0] pin_in,
  output logic [7:0]      tx_byte,
  output logic            tx_req,
  output logic [2*HW-1:0] out_bits,
  output logic [2*HW-1:0] dir_bits,
  output logic            irq_pending,
  output logic            irq_enable,
  output logic [7:0]      trim
);
  localparam int W = 2 * HW;
  localparam int IW = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] raw_q, cmp_q, dir_q, lo_q, hi_q, rise_q, fall_q, out_q;
  logic         pend_q, en_q, wait_q, txreq_q;
  logic [3:0]   opc_q;
  logic [IW-1:0] idx_q;
  logic [7:0]   glitch_q, tx_q, rd;
  logic [HW-1:0] opnd;

  wire [W-1:0] inputs = raw_q ^ cmp_q;
  wire cmd_ok = rx_valid && !wait_q;
  wire full_clr = cmd_ok && (rx_byte == 8'h17);
  wire [7:0] id_byte = 8'(ID_SEED + ID_STEP * 8'(idx_q));

  function automatic logic [7:0] half(input logic [W-1:0] v, input logic sel);
    return sel ? 8'(v[W-1:HW]) : 8'(v[HW-1:0]);
  endfunction

  function automatic logic [W-1:0] put(input logic [W-1:0] v, input logic sel,
                                       input logic [HW-1:0] d);
    return sel ? {d, v[HW-1:0]} : {v[W-1:HW], d};
  endfunction

  assign opnd = rx_byte[HW-1:0];

  always_comb begin
    case (rx_byte[3:1])
      3'd0: rd = half(inputs, rx_byte[0]);
      3'd1: rd = half(cmp_q, rx_byte[0]);
      3'd2: rd = half(dir_q, rx_byte[0]);
      3'd3: rd = half(raw_q, rx_byte[0]);
      3'd4: rd = half(lo_q, rx_byte[0]);
      3'd5: rd = half(hi_q, rx_byte[0]);
      3'd6: rd = half(rise_q, rx_byte[0]);
      default: rd = half(fall_q, rx_byte[0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trim <= TRIM_INIT;
    else if (cmd_ok && rx_byte == 8'hF8) trim <= trim - TRIM_STEP;
    else if (cmd_ok && rx_byte == 8'hF9) trim <= trim + TRIM_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0; dir_q <= ONES; lo_q <= '0; hi_q <= '0;
      rise_q <= '0; fall_q <= '0; out_q <= '0;
      pend_q <= 1'b0; en_q <= 1'b0; wait_q <= 1'b0; opc_q <= '0;
      idx_q <= '0; glitch_q <= '0; tx_q <= '0; txreq_q <= 1'b0;
    end else if (full_clr) begin
      cmp_q <= '0; dir_q <= ONES; lo_q <= '0; hi_q <= '0;
      rise_q <= '0; fall_q <= '0; out_q <= '0;
      pend_q <= 1'b0; en_q <= 1'b0; wait_q <= 1'b0; opc_q <= '0;
      idx_q <= '0; glitch_q <= '0; tx_q <= '0; txreq_q <= 1'b0;
    end else begin
      txreq_q <= 1'b0;
      if (rx_valid && wait_q) begin
        wait_q <= 1'b0;
        case (opc_q[3:1])
          3'd1: cmp_q <= put(cmp_q, opc_q[0], opnd);
          3'd2: dir_q <= put(dir_q, opc_q[0], opnd);
          3'd4: lo_q <= put(lo_q, opc_q[0], opnd);
          3'd5: hi_q <= put(hi_q, opc_q[0], opnd);
          3'd6: rise_q <= put(rise_q, opc_q[0], opnd);
          3'd7: fall_q <= put(fall_q, opc_q[0], opnd);
          default: ;
        endcase
      end else if (rx_valid) begin
        casez (rx_byte)
          8'b0000_????: begin tx_q <= rd; txreq_q <= 1'b1; end
          8'h10, 8'h11: begin tx_q <= half(out_q, rx_byte[0]); txreq_q <= 1'b1; end
          8'h12, 8'h13, 8'h14, 8'h15, 8'b0001_1???: begin
            wait_q <= 1'b1;
            opc_q <= rx_byte[3:0];
          end
          8'h16: out_q <= '0;
          8'b001?_????: out_q <= put(out_q, 1'b0, opnd);
          8'b010?_????: out_q <= put(out_q, 1'b1, opnd);
          8'b011?_????: if (32'(rx_byte[3:0]) < W) out_q[rx_byte[3:0]] <= rx_byte[4];
          8'hEF: begin tx_q <= {6'd0, en_q, pend_q}; txreq_q <= 1'b1; end
          8'b1111_00??: begin en_q <= rx_byte[1]; pend_q <= rx_byte[0]; end
          8'b1111_010?: pend_q <= rx_byte[0];
          8'b1111_011?: en_q <= rx_byte[0];
          8'hFA: begin tx_q <= trim; txreq_q <= 1'b1; end
          8'hFB: begin tx_q <= 8'h00; txreq_q <= 1'b1; end
          8'hFC: begin
            tx_q <= id_byte; txreq_q <= 1'b1;
            idx_q <= (idx_q == IW'(ID_LEN - 1)) ? '0 : idx_q + 1'b1;
          end
          8'hFD: idx_q <= '0;
          8'hFE: begin tx_q <= glitch_q; txreq_q <= 1'b1; glitch_q <= '0; end
          8'hFF: if (glitch_q != 8'hFF) glitch_q <= glitch_q + 8'd1;
          default: ;
        endcase
      end
    end
  end

  assign tx_byte = tx_q;
  assign tx_req = txreq_q;
  assign out_bits = out_q;
  assign dir_bits = dir_q;
  assign irq_pending = pend_q;
  assign irq_enable = en_q;

  // R13
  reply_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(rx_valid));

  // R4
  operand_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && wait_q) |=> !tx_req);

  // R7
  bit_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && rx_byte[7:5] == 3'b011 && 32'(rx_byte[3:0]) >= W) |=> $stable(out_bits));

  // R8
  noop_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && rx_byte[7:6] == 2'b10) |=> ($stable(out_bits) && $stable(dir_bits) && !tx_req));

  // R11
  id_pointer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < ID_LEN);

  // R12
  glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && rx_byte == 8'hFF && glitch_q == 8'hFF) |=> (glitch_q == 8'hFF));
endmodule

// File: tb/ioexp_cmd_decoder_bench.sv
module ioexp_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0;
  logic [9:0] pin_in = 10'h2CD;
  logic [7:0] tx_byte, trim;
  logic tx_req, irq_pending, irq_enable;
  logic [9:0] out_bits, dir_bits;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ioexp_cmd_decoder u_ioexp_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .pin_in(pin_in), .tx_byte(tx_byte), .tx_req(tx_req),
    .out_bits(out_bits), .dir_bits(dir_bits), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .trim(trim)
  );

  function automatic logic [7:0] id_at(input int k);
    return 8'(8'h49 + 8'h11 * k);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit reply, input logic [7:0] exp,
                      input string tag);
    if (reply) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    rx_byte = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    check({"R13 reply strobe ", tag}, 32'(tx_req), 32'(reply));
    @(negedge clk);
    check("R13 single-cycle strobe", 32'(tx_req), 0);
  endtask

  always @(negedge clk) begin
    if (tx_req) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13 unexpected reply actual=0x%0h expected=none", tx_byte);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (tx_byte !== e) begin
          n_fail++;
          $display("FAIL %s reply actual=0x%0h expected=0x%0h", t, tx_byte, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs", 32'(out_bits), 0);
    check("R1 direction", 32'(dir_bits), 32'h3FF);
    check("R1 irq", 32'({irq_enable, irq_pending}), 0);
    check("R1 trim", 32'(trim), 32'h80);
    check("R1 tx_req", 32'(tx_req), 0);
    send(8'hFE, 1, 8'h00, "R1 glitch");
    send(8'hFC, 1, id_at(0), "R1 id pointer");
    send(8'hFD, 0, 0, "R11 rewind");

    send(8'h06, 1, 8'h0D, "R2 raw low");
    send(8'h07, 1, 8'h16, "R2 raw high");
    send(8'h00, 1, 8'h0D, "R2 input low");
    send(8'h05, 1, 8'h1F, "R2 direction high");

    send(8'h12, 0, 0, "R4 opcode");
    send(8'hFF, 0, 0, "R4 operand");
    send(8'h02, 1, 8'h1F, "R4 complement low");
    send(8'h00, 1, 8'h12, "R2 inverted input low");
    send(8'h14, 0, 0, "R4 opcode");
    send(8'h17, 0, 0, "R4 operand not opcode");
    check("R4 direction", 32'(dir_bits), 32'h3F7);
    send(8'h04, 1, 8'h17, "R4 direction low");
    send(8'h1B, 0, 0, "R4 opcode");
    send(8'hE5, 0, 0, "R4 operand");
    send(8'h0B, 1, 8'h05, "R4 high mask high");
    send(8'h1E, 0, 0, "R4 opcode");
    send(8'h0A, 0, 0, "R4 operand");
    send(8'h0E, 1, 8'h0A, "R4 falling mask low");
    send(8'h0F, 1, 8'h00, "R2 falling mask high");

    send(8'h35, 0, 0, "R6 low load");
    send(8'h4A, 0, 0, "R6 high load");
    check("R6 outputs", 32'(out_bits), 32'h155);
    send(8'h10, 1, 8'h15, "R3 output low");
    send(8'h11, 1, 8'h0A, "R3 output high");

    send(8'h71, 0, 0, "R7 set bit1");
    check("R7 set bit1", 32'(out_bits), 32'h157);
    send(8'h68, 0, 0, "R7 clear bit8");
    check("R7 clear bit8", 32'(out_bits), 32'h057);
    send(8'h7C, 0, 0, "R7 bit12");
    check("R7 bit12 ignored", 32'(out_bits), 32'h057);

    send(8'h80, 0, 0, "R8 10xxxxxx");
    send(8'hC5, 0, 0, "R8 110xxxxx");
    send(8'hE3, 0, 0, "R8 11100xxx");
    send(8'hE9, 0, 0, "R8 11101xxx");
    check("R8 outputs", 32'(out_bits), 32'h057);
    check("R8 direction", 32'(dir_bits), 32'h3F7);
    check("R8 irq", 32'({irq_enable, irq_pending}), 0);

    send(8'hF3, 0, 0, "R9 both");
    send(8'hEF, 1, 8'h03, "R9 read both");
    send(8'hF4, 0, 0, "R9 pending off");
    send(8'hEF, 1, 8'h02, "R9 read enable only");
    send(8'hF6, 0, 0, "R9 enable off");
    send(8'hF5, 0, 0, "R9 pending on");
    send(8'hEF, 1, 8'h01, "R9 read pending only");
    check("R9 port bits", 32'({irq_enable, irq_pending}), 32'h1);

    send(8'hF8, 0, 0, "R10 dec");
    check("R10 trim dec", 32'(trim), 32'h7C);
    send(8'hFA, 1, 8'h7C, "R10 read");
    send(8'hF9, 0, 0, "R10 inc");
    send(8'hF9, 0, 0, "R10 inc");
    send(8'hFA, 1, 8'h84, "R10 read");
    send(8'hFB, 1, 8'h00, "R10 pulse");

    for (int k = 0; k < 7; k++) send(8'hFC, 1, id_at(k % 6), "R11 id walk");
    send(8'hFD, 0, 0, "R11 rewind");
    send(8'hFC, 1, id_at(0), "R11 after rewind");

    for (int k = 0; k < 3; k++) send(8'hFF, 0, 0, "R12 bump");
    send(8'hFE, 1, 8'h03, "R12 read count");
    send(8'hFE, 1, 8'h00, "R12 cleared");
    for (int k = 0; k < 260; k++) send(8'hFF, 0, 0, "R12 bump");
    send(8'hFE, 1, 8'hFF, "R12 saturated");

    send(8'h16, 0, 0, "R5 clear outputs");
    check("R5 outputs cleared", 32'(out_bits), 0);
    send(8'h3F, 0, 0, "R6 load");
    send(8'hFF, 0, 0, "R12 bump");
    send(8'hF3, 0, 0, "R9 both");
    send(8'h17, 0, 0, "R5 full reset");
    check("R5 outputs", 32'(out_bits), 0);
    check("R5 direction", 32'(dir_bits), 32'h3FF);
    check("R5 irq", 32'({irq_enable, irq_pending}), 0);
    check("R5 trim kept", 32'(trim), 32'h84);
    send(8'h02, 1, 8'h00, "R5 complement");
    send(8'h0E, 1, 8'h00, "R5 falling mask");
    send(8'hFE, 1, 8'h00, "R5 glitch");
    send(8'hFC, 1, id_at(0), "R5 id pointer");

    repeat (2) @(negedge clk);
    check("R13 replies all delivered", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule